// File: doc/BRIEF.md
# SPI Radio Command Slave

This block is the serial command front end of a radio transceiver. An external master drives a four-wire SPI link (mode 0, most significant bit first) and reaches two stores behind the block: a file of 64 eight-bit control registers and a 128-byte frame buffer. Each transaction opens when chip select goes low and closes when it goes high. The first byte of a transaction is a command, and the command decides how the following bytes are read.

The commands cover single register reads and writes, bursts into and out of the frame buffer at any start address, and two frame-level accesses. A frame write takes a length byte and then the payload. A frame read returns the stored length, then the payload, then a one-byte link-quality value. Every byte exchange is full duplex, so the master sends dummy zeros while it reads. A sideband load port stands in for the receiver. It places received bytes into the frame buffer and sets the frame length and the quality byte.

The SPI pins are brought into the system clock domain through two-flop synchronizers. Edges are detected on the synchronized clock: input bits are captured on the rising edge, and output bits are shifted on the falling edge.

Top module: `radio_cmd_spi`

## Requirements
- R1: A command byte whose two top bits are 2'b10 reads a register. Bits [5:0] are the address, and the register value is returned on MISO during the next byte.
- R2: A command byte whose two top bits are 2'b11 writes a register. The next byte received is stored at address bits [5:0], and a later read of that address returns it.
- R3: Command 0x60 is a frame write. The next byte is the frame length, stored with bit 7 forced to 0. The bytes after it are stored in the frame buffer in order, starting at address 0.
- R4: Command 0x20 is a frame read. The byte after the command returns the stored length L. The next L bytes return frame buffer addresses 0 to L-1. The byte after those returns the quality byte, and any further bytes return 0x00.
- R5: Command 0x00 is a burst buffer read. The next byte gives a start address in bits [6:0]. The following bytes return buffer data from that address upward, and the address wraps from 127 to 0.
- R6: Command 0x40 is a burst buffer write. The next byte gives a start address in bits [6:0]. The following bytes are stored from that address upward, and the address wraps from 127 to 0.
- R7: The byte returned while the command byte is shifted in is 0x00, and MISO is low whenever chip select is high.
- R8: If chip select rises partway through a byte, those bits are discarded and nothing is written. The next transaction decodes its first byte as a fresh command.
- R9: After reset every register, every buffer byte, the frame length and the quality byte are zero.
- R10: A sideband byte load writes one frame buffer byte. A sideband frame load sets the length (bit 7 forced to 0) and the quality byte. A later frame read returns all of these values.
- R11: A command byte that matches none of the codes above returns 0x00 for the rest of the transaction and changes no register, buffer byte or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock, idles low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| ld_buf_we | input | 1 | Sideband strobe that writes one frame buffer byte |
| ld_buf_addr | input | 7 | Sideband buffer address |
| ld_buf_data | input | 8 | Sideband buffer data |
| ld_frame_we | input | 1 | Sideband strobe that sets the frame length and quality byte |
| ld_frame_len | input | 8 | Sideband frame length |
| ld_frame_lqi | input | 8 | Sideband link-quality byte |

## Verification
Each SPI pin passes through two synchronizer flops, and the edge detector adds one more register. A received bit therefore takes effect about three system clocks after its SCK edge, and the shifted output bit appears on MISO about three clocks after the falling edge. A byte selected by a command or address byte is loaded at the eighth rising edge of that byte, and the master sees it on the very next byte. A write lands in the stores one clock after the byte completes, so it is visible in the next transaction. The bench holds each SCK level for eight system clocks and samples MISO just before raising SCK, which keeps every sample well clear of these three-clock latencies.

// File: rtl/radio_spi_pkg.sv
package radio_spi_pkg;

    typedef enum logic [3:0] {
        ST_CMD,
        ST_REG_WR,
        ST_FRD_DATA,
        ST_FWR_LEN,
        ST_FWR_DATA,
        ST_BRD_ADDR,
        ST_BRD_DATA,
        ST_BWR_ADDR,
        ST_BWR_DATA,
        ST_SKIP
    } cmd_state_e;

    localparam logic [1:0] TOP_REG_RD   = 2'b10;
    localparam logic [1:0] TOP_REG_WR   = 2'b11;
    localparam logic [7:0] OP_FRAME_RD  = 8'h20;
    localparam logic [7:0] OP_FRAME_WR  = 8'h60;
    localparam logic [7:0] OP_MEM_RD    = 8'h00;
    localparam logic [7:0] OP_MEM_WR    = 8'h40;

endpackage

// File: rtl/radio_spi_sync.sv
module radio_spi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    // chain_q[0] is the first stage, chain_q[STAGES-1] the last
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_in};
        end
    end

    assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/radio_spi_shifter.sv
module radio_spi_shifter #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_val,
    output logic              miso
);
    typedef struct packed {
        logic              sck_prev;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
    } shift_t;

    shift_t q, d;
    logic   rise, fall;

    always_comb begin
        d          = q;
        d.sck_prev = sck_s;
        rise       = sck_s & ~q.sck_prev;
        fall       = ~sck_s & q.sck_prev;
        byte_val   = {q.rx[BYTE_W-2:0], mosi_s};
        byte_stb   = ~cs_n_s & rise & (q.cnt == CNT_W'(BYTE_W - 1));
        if (cs_n_s) begin
            d.cnt = '0;
            d.rx  = '0;
            d.tx  = '0;
        end else if (rise) begin
            d.rx  = byte_val;
            d.cnt = byte_stb ? '0 : q.cnt + 1'b1;
            if (byte_stb) begin
                d.tx = load_byte;
            end
        end else if (fall && (q.cnt != '0)) begin
            d.tx = {q.tx[BYTE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign miso = q.tx[BYTE_W-1];

    // R7
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !miso);

    // R1
    load_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> (miso == $past(load_byte[BYTE_W-1])));

endmodule

// File: rtl/radio_spi_store.sv
module radio_spi_store #(
    parameter int DATA_W = 8,
    parameter int REG_AW = 6,
    parameter int BUF_AW = 7,
    localparam int REGS  = 1 << REG_AW,
    localparam int BYTES = 1 << BUF_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [BUF_AW-1:0] buf_raddr,
    output logic [DATA_W-1:0] buf_rdata,
    input  logic              buf_we,
    input  logic [BUF_AW-1:0] buf_waddr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              sb_buf_we,
    input  logic [BUF_AW-1:0] sb_buf_addr,
    input  logic [DATA_W-1:0] sb_buf_data,
    input  logic              len_we,
    input  logic [DATA_W-1:0] len_wdata,
    input  logic              sb_frame_we,
    input  logic [DATA_W-1:0] sb_len,
    input  logic [DATA_W-1:0] sb_lqi,
    output logic [DATA_W-1:0] len_val,
    output logic [DATA_W-1:0] lqi_val
);
    typedef struct packed {
        logic [DATA_W-1:0] len;
        logic [DATA_W-1:0] lqi;
    } frame_info_t;

    logic [DATA_W-1:0] regs_q [REGS];
    logic [DATA_W-1:0] buf_q  [BYTES];
    frame_info_t       q, d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REGS; i++) regs_q[i] <= '0;
        end else if (reg_we) begin
            regs_q[reg_waddr] <= reg_wdata;
        end
    end

    // the SPI port is written last, so it wins a same-address collision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) buf_q[i] <= '0;
        end else begin
            if (sb_buf_we) buf_q[sb_buf_addr] <= sb_buf_data;
            if (buf_we)    buf_q[buf_waddr]   <= buf_wdata;
        end
    end

    always_comb begin
        d = q;
        if (sb_frame_we) begin
            d.len = {1'b0, sb_len[DATA_W-2:0]};
            d.lqi = sb_lqi;
        end
        if (len_we) begin
            d.len = {1'b0, len_wdata[DATA_W-2:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign reg_rdata = regs_q[reg_raddr];
    assign buf_rdata = buf_q[buf_raddr];
    assign len_val   = q.len;
    assign lqi_val   = q.lqi;

    // R3
    len_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.len[DATA_W-1]);

endmodule

// File: rtl/radio_spi_cmd.sv
module radio_spi_cmd
    import radio_spi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int REG_AW = 6,
    parameter int BUF_AW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_val,
    output logic [DATA_W-1:0] tx_byte,
    output logic [REG_AW-1:0] reg_raddr,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_we,
    output logic [REG_AW-1:0] reg_waddr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic [BUF_AW-1:0] buf_raddr,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_waddr,
    output logic [DATA_W-1:0] buf_wdata,
    output logic              len_we,
    output logic [DATA_W-1:0] len_wdata,
    input  logic [DATA_W-1:0] len_val,
    input  logic [DATA_W-1:0] lqi_val
);
    typedef struct packed {
        cmd_state_e        state;
        logic [REG_AW-1:0] addr;
        logic [BUF_AW-1:0] ptr;
        logic [BUF_AW-1:0] cnt;
    } cmd_t;

    cmd_t q, d;

    always_comb begin
        d         = q;
        tx_byte   = '0;
        reg_raddr = byte_val[REG_AW-1:0];
        reg_we    = 1'b0;
        reg_waddr = q.addr;
        reg_wdata = byte_val;
        buf_raddr = (q.state == ST_BRD_ADDR) ? byte_val[BUF_AW-1:0] : q.ptr;
        buf_we    = 1'b0;
        buf_waddr = q.ptr;
        buf_wdata = byte_val;
        len_we    = 1'b0;
        len_wdata = byte_val;
        if (cs_n_s) begin
            d.state = ST_CMD;
            d.ptr   = '0;
            d.cnt   = '0;
        end else if (byte_stb) begin
            case (q.state)
                ST_CMD: begin
                    if (byte_val[DATA_W-1 -: 2] == TOP_REG_RD) begin
                        tx_byte = reg_rdata;
                        d.state = ST_SKIP;
                    end else if (byte_val[DATA_W-1 -: 2] == TOP_REG_WR) begin
                        d.addr  = byte_val[REG_AW-1:0];
                        d.state = ST_REG_WR;
                    end else begin
                        case (byte_val)
                            OP_FRAME_RD: begin
                                tx_byte = len_val;
                                d.ptr   = '0;
                                d.cnt   = len_val[BUF_AW-1:0];
                                d.state = ST_FRD_DATA;
                            end
                            OP_FRAME_WR: d.state = ST_FWR_LEN;
                            OP_MEM_RD:   d.state = ST_BRD_ADDR;
                            OP_MEM_WR:   d.state = ST_BWR_ADDR;
                            default:     d.state = ST_SKIP;
                        endcase
                    end
                end
                ST_REG_WR: begin
                    reg_we  = 1'b1;
                    d.state = ST_SKIP;
                end
                ST_FRD_DATA: begin
                    if (q.cnt != '0) begin
                        tx_byte = buf_rdata;
                        d.ptr   = q.ptr + 1'b1;
                        d.cnt   = q.cnt - 1'b1;
                    end else begin
                        tx_byte = lqi_val;
                        d.state = ST_SKIP;
                    end
                end
                ST_FWR_LEN: begin
                    len_we  = 1'b1;
                    d.ptr   = '0;
                    d.state = ST_FWR_DATA;
                end
                ST_FWR_DATA, ST_BWR_DATA: begin
                    buf_we = 1'b1;
                    d.ptr  = q.ptr + 1'b1;
                end
                ST_BRD_ADDR: begin
                    tx_byte = buf_rdata;
                    d.ptr   = byte_val[BUF_AW-1:0] + 1'b1;
                    d.state = ST_BRD_DATA;
                end
                ST_BRD_DATA: begin
                    tx_byte = buf_rdata;
                    d.ptr   = q.ptr + 1'b1;
                end
                ST_BWR_ADDR: begin
                    d.ptr   = byte_val[BUF_AW-1:0];
                    d.state = ST_BWR_DATA;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_CMD, default: '0};
        end else begin
            q <= d;
        end
    end

    // R8
    cs_return_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (q.state == ST_CMD));

    // R2
    reg_write_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (q.state == ST_SKIP || q.state == ST_CMD));

    // R5
    burst_rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !cs_n_s && q.state == ST_BRD_DATA) |=>
            (q.ptr == BUF_AW'($past(q.ptr) + 1'b1)));

    // R11
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SKIP) |-> !(buf_we || len_we || reg_we));

endmodule

// File: rtl/radio_cmd_spi.sv
module radio_cmd_spi #(
    parameter int DATA_W = 8,
    parameter int REG_AW = 6,
    parameter int BUF_AW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              ld_buf_we,
    input  logic [BUF_AW-1:0] ld_buf_addr,
    input  logic [DATA_W-1:0] ld_buf_data,
    input  logic              ld_frame_we,
    input  logic [DATA_W-1:0] ld_frame_len,
    input  logic [DATA_W-1:0] ld_frame_lqi
);
    logic              cs_n_s, sck_s, mosi_s;
    logic              byte_stb;
    logic [DATA_W-1:0] byte_val, tx_byte;
    logic [REG_AW-1:0] reg_raddr, reg_waddr;
    logic [DATA_W-1:0] reg_rdata, reg_wdata;
    logic              reg_we, buf_we, len_we;
    logic [BUF_AW-1:0] buf_raddr, buf_waddr;
    logic [DATA_W-1:0] buf_rdata, buf_wdata, len_wdata, len_val, lqi_val;

    radio_spi_sync #(
        .WIDTH   (3),
        .STAGES  (2),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({spi_mosi, spi_sck, spi_cs_n}),
        .d_out ({mosi_s, sck_s, cs_n_s})
    );

    radio_spi_shifter #(.BYTE_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .sck_s     (sck_s),
        .mosi_s    (mosi_s),
        .load_byte (tx_byte),
        .byte_stb  (byte_stb),
        .byte_val  (byte_val),
        .miso      (spi_miso)
    );

    radio_spi_cmd #(.DATA_W(DATA_W), .REG_AW(REG_AW), .BUF_AW(BUF_AW)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .byte_stb  (byte_stb),
        .byte_val  (byte_val),
        .tx_byte   (tx_byte),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .buf_raddr (buf_raddr),
        .buf_rdata (buf_rdata),
        .buf_we    (buf_we),
        .buf_waddr (buf_waddr),
        .buf_wdata (buf_wdata),
        .len_we    (len_we),
        .len_wdata (len_wdata),
        .len_val   (len_val),
        .lqi_val   (lqi_val)
    );

    radio_spi_store #(.DATA_W(DATA_W), .REG_AW(REG_AW), .BUF_AW(BUF_AW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_raddr   (reg_raddr),
        .reg_rdata   (reg_rdata),
        .reg_we      (reg_we),
        .reg_waddr   (reg_waddr),
        .reg_wdata   (reg_wdata),
        .buf_raddr   (buf_raddr),
        .buf_rdata   (buf_rdata),
        .buf_we      (buf_we),
        .buf_waddr   (buf_waddr),
        .buf_wdata   (buf_wdata),
        .sb_buf_we   (ld_buf_we),
        .sb_buf_addr (ld_buf_addr),
        .sb_buf_data (ld_buf_data),
        .len_we      (len_we),
        .len_wdata   (len_wdata),
        .sb_frame_we (ld_frame_we),
        .sb_len      (ld_frame_len),
        .sb_lqi      (ld_frame_lqi),
        .len_val     (len_val),
        .lqi_val     (lqi_val)
    );

endmodule

// File: tb/radio_cmd_spi_test.sv
module radio_cmd_spi_test;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic       miso;
    logic       ld_buf_we = 1'b0, ld_frame_we = 1'b0;
    logic [6:0] ld_buf_addr = '0;
    logic [7:0] ld_buf_data = '0, ld_frame_len = '0, ld_frame_lqi = '0;

    logic [7:0] regs_m [64];
    logic [7:0] buf_m  [128];
    logic [7:0] len_m, lqi_m;
    logic [7:0] scr    [128];
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    radio_cmd_spi uut (
        .clk (clk), .rst_n (rst_n), .spi_cs_n (cs_n), .spi_sck (sck),
        .spi_mosi (mosi), .spi_miso (miso), .ld_buf_we (ld_buf_we),
        .ld_buf_addr (ld_buf_addr), .ld_buf_data (ld_buf_data),
        .ld_frame_we (ld_frame_we), .ld_frame_len (ld_frame_len),
        .ld_frame_lqi (ld_frame_lqi)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        ticks(H);
    endtask

    task automatic cs_end();
        ticks(H);
        cs_n = 1'b1;
        ticks(2 * H);
    endtask

    task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            ticks(H);
            rx[i] = miso;
            sck = 1'b1;
            ticks(H);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        bits(tx, 8, rx);
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [7:0] v);
        logic [7:0] r;
        cs_begin();
        xfer({2'b11, a}, r);
        chk("R7 command byte echo", r, 8'h00);
        xfer(v, r);
        cs_end();
        regs_m[a] = v;
    endtask

    task automatic reg_read(input logic [5:0] a);
        logic [7:0] r;
        cs_begin();
        xfer({2'b10, a}, r);
        chk("R7 command byte echo", r, 8'h00);
        xfer(8'h00, r);
        chk("R1 register read", r, regs_m[a]);
        cs_end();
    endtask

    task automatic mem_write(input logic [6:0] a, input int n);
        logic [7:0] r;
        cs_begin();
        xfer(8'h40, r);
        xfer({1'b0, a}, r);
        for (int i = 0; i < n; i++) begin
            xfer(scr[i], r);
            buf_m[7'(a + 7'(i))] = scr[i];
        end
        cs_end();
    endtask

    task automatic mem_read(input logic [6:0] a, input int n);
        logic [7:0] r;
        cs_begin();
        xfer(8'h00, r);
        xfer({1'b0, a}, r);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, r);
            chk("R5 burst read", r, buf_m[7'(a + 7'(i))]);
        end
        cs_end();
    endtask

    task automatic frame_write(input logic [7:0] len, input int n);
        logic [7:0] r;
        cs_begin();
        xfer(8'h60, r);
        xfer(len, r);
        for (int i = 0; i < n; i++) begin
            xfer(scr[i], r);
            buf_m[i % 128] = scr[i];
        end
        cs_end();
        len_m = {1'b0, len[6:0]};
    endtask

    task automatic frame_read();
        logic [7:0] r;
        cs_begin();
        xfer(8'h20, r);
        chk("R7 command byte echo", r, 8'h00);
        xfer(8'h00, r);
        chk("R3 R4 frame length", r, len_m);
        for (int i = 0; i < int'(len_m); i++) begin
            xfer(8'h00, r);
            chk("R4 frame data", r, buf_m[i]);
        end
        xfer(8'h00, r);
        chk("R4 quality byte", r, lqi_m);
        xfer(8'h00, r);
        chk("R4 trailing zero", r, 8'h00);
        cs_end();
    endtask

    task automatic sb_byte(input logic [6:0] a, input logic [7:0] v);
        ld_buf_addr = a;
        ld_buf_data = v;
        ld_buf_we = 1'b1;
        ticks(1);
        ld_buf_we = 1'b0;
        buf_m[a] = v;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 64; i++)  regs_m[i] = '0;
        for (int i = 0; i < 128; i++) buf_m[i] = '0;
        len_m = '0;
        lqi_m = '0;
        ticks(5);
        rst_n = 1'b1;
        ticks(5);

        // R9 reset state, R7 idle MISO
        chk("R7 idle MISO", {7'b0, miso}, 8'h00);
        reg_read(6'd0);
        reg_read(6'd63);
        mem_read(7'd0, 4);
        frame_read();

        // R1 R2 directed
        reg_write(6'h2A, 8'hA5);
        reg_write(6'h3F, 8'h3C);
        reg_read(6'h2A);
        reg_read(6'h3F);
        reg_read(6'h29);

        // R6 R5 wrap at the top of the buffer
        for (int i = 0; i < 5; i++) scr[i] = 8'hB0 + 8'(i);
        mem_write(7'd126, 5);
        mem_read(7'd125, 6);
        chk("R7 idle MISO", {7'b0, miso}, 8'h00);

        // R3 length MSB cleared, R4 readback
        for (int i = 0; i < 5; i++) scr[i] = 8'hC1 + 8'(i);
        frame_write(8'h85, 5);
        frame_read();

        // R10 sideband load
        for (int i = 0; i < 10; i++) sb_byte(7'(i), 8'($urandom));
        ld_frame_len = 8'h8A;
        ld_frame_lqi = 8'hC7;
        ld_frame_we = 1'b1;
        ticks(1);
        ld_frame_we = 1'b0;
        len_m = 8'h0A;
        lqi_m = 8'hC7;
        frame_read();

        // R8 partial data byte then fresh command
        reg_write(6'd5, 8'h11);
        cs_begin();
        xfer(8'hC5, r);
        bits(8'hFF, 5, r);
        cs_end();
        reg_read(6'd5);
        cs_begin();
        bits(8'h47, 3, r);
        cs_end();
        reg_read(6'd5);

        // R11 unknown command
        cs_begin();
        xfer(8'h13, r);
        for (int i = 0; i < 3; i++) begin
            xfer(8'hFF, r);
            chk("R11 unknown command returns zero", r, 8'h00);
        end
        cs_end();
        reg_read(6'h13);
        frame_read();

        // random mix
        for (int k = 0; k < 30; k++) begin
            int op;
            int n;
            logic [6:0] a;
            op = int'($urandom % 6);
            n = 1 + int'($urandom % 8);
            a = 7'($urandom);
            for (int i = 0; i < n; i++) scr[i] = 8'($urandom);
            case (op)
                0: reg_write(a[5:0], scr[0]);
                1: reg_read(a[5:0]);
                2: mem_write(a, n);
                3: mem_read(a, n);
                4: frame_write(8'(n + int'($urandom % 2) * 128), n);
                default: frame_read();
            endcase
        end

        // R3 R4 maximum frame
        for (int i = 0; i < 127; i++) scr[i] = 8'(i * 3 + 7);
        frame_write(8'd127, 127);
        frame_read();

        summary();
        $finish;
    end

endmodule